// File: doc/BRIEF.md
# Left Shift Unit with Status Flags

This block is the left-shift slice of a 16-bit processor datapath. It takes one operand and moves it one place to the left, either as a plain shift that brings in a zero or as a rotate that brings in the current carry flag. A mode input selects whether the full word or only the low byte is active. Along with the result, the unit produces carry, zero, negative and overflow flags for the active width.

The flags are the same whether the operand holds a signed or an unsigned value. Overflow reports that the top two bits of the active width were different, so it is set whenever the value leaves the signed range. Surrounding code that treats the value as unsigned can ignore it. A 32-bit shift is built from two operations. First shift the low word, then rotate the high word using the carry that came out of the first step.

The result and flags are registered. They appear one clock after the input strobe, together with a one-cycle valid pulse.

Top module: `shl_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `result`, `out_valid` and all four flags to 0.
- R2: When `in_valid` is high at a rising edge, the outputs for that operand appear after that edge with `out_valid` high for exactly one cycle. When `in_valid` is low, `out_valid` goes low and `result` and the flags keep their values.
- R3: Word mode (`byte_mode`=0) with `use_carry`=0 gives `result` = (operand*2) mod 65536; bit 0 is zero.
- R4: With `use_carry`=1, bit 0 of the active result equals `carry_in` sampled with the operand.
- R5: Byte mode (`byte_mode`=1) gives `result[7:0]` = (operand[7:0]*2 + fill) mod 256 and `result[15:8]` = 0; operand bits 15..8 have no effect.
- R6: `flag_c` equals operand bit 15 in word mode and operand bit 7 in byte mode.
- R7: `flag_z` is 1 exactly when the active-width result is zero.
- R8: `flag_n` equals result bit 15 in word mode and result bit 7 in byte mode.
- R9: `flag_v` is 1 exactly when the operand lies in 0x4000..0xBFFF (word mode) or its low byte lies in 0x40..0xBF (byte mode), i.e. when the two top bits of the active width differ. Example: 0x4000 in word mode gives 0x8000 with `flag_v`=1.
- R10: Shifting a low word and then rotating the high word, with `carry_in` set to the first step's `flag_c`, yields the 32-bit value shifted left by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| operand | input | 16 | Value to shift |
| byte_mode | input | 1 | 1: low byte active, 0: full word |
| use_carry | input | 1 | 1: fill with carry_in, 0: fill with zero |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | One-cycle pulse marking new outputs |
| result | output | 16 | Shifted value |
| flag_c | output | 1 | Bit shifted out of the active width |
| flag_z | output | 1 | Active-width result is zero |
| flag_n | output | 1 | Top bit of the active-width result |
| flag_v | output | 1 | Top two operand bits of the active width differ |

## Verification
The checker assumes that `byte_mode`, `use_carry`, `carry_in` and `operand` are settled at the rising edge where `in_valid` is high. It compares each flag with the values those inputs had at the previous edge. It also assumes that no strobe arrives while reset is held. The stimulus changes inputs only on falling edges, keeps `in_valid` low during reset, and sweeps every word operand and every byte operand under both fill choices. It then adds idle gaps, a reset in the middle of the run and a two-step 32-bit sequence.

// File: rtl/shl_flag_unit.sv
module shl_flag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] operand,
  input  logic         byte_mode,
  input  logic         use_carry,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v
);
  localparam int H = W / 2;

  logic         fill;
  logic [W-1:0] word_res;
  logic [W-1:0] byte_res;
  logic [W-1:0] nxt_res;
  logic         nxt_c, nxt_z, nxt_n, nxt_v;

  assign fill     = use_carry & carry_in;
  assign word_res = {operand[W-2:0], fill};
  assign byte_res = {{H{1'b0}}, operand[H-2:0], fill};
  assign nxt_res  = byte_mode ? byte_res : word_res;
  assign nxt_c    = byte_mode ? operand[H-1] : operand[W-1];
  assign nxt_v    = byte_mode ? (operand[H-1] ^ operand[H-2])
                              : (operand[W-1] ^ operand[W-2]);
  assign nxt_n    = byte_mode ? nxt_res[H-1] : nxt_res[W-1];
  assign nxt_z    = byte_mode ? (nxt_res[H-1:0] == '0) : (nxt_res == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        flag_c <= nxt_c;
        flag_z <= nxt_z;
        flag_n <= nxt_n;
        flag_v <= nxt_v;
      end
    end
  end
endmodule

// File: rtl/shl_flag_unit_chk.sv
module shl_flag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] operand,
  input logic         byte_mode,
  input logic         use_carry,
  input logic         carry_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_c,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_v
);
  localparam int H = W / 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !flag_c && !flag_z && !flag_n && !flag_v));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c) && $stable(flag_v)));

  a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_mode) |=> result[W-1:H] == '0);

  a_r4_fill_bit: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[0] == $past(use_carry & carry_in));

  a_r6_carry_out: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_c == $past(byte_mode ? operand[H-1] : operand[W-1]));

  a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_v == $past(byte_mode ? (operand[H-1] ^ operand[H-2])
                                           : (operand[W-1] ^ operand[W-2])));

  a_r8_negative: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_n == ($past(byte_mode) ? result[H-1] : result[W-1]));

  a_r7_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_z == ($past(byte_mode) ? (result[H-1:0] == '0) : (result == '0)));
endmodule

bind shl_flag_unit shl_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
  .byte_mode(byte_mode), .use_carry(use_carry), .carry_in(carry_in),
  .out_valid(out_valid), .result(result), .flag_c(flag_c), .flag_z(flag_z),
  .flag_n(flag_n), .flag_v(flag_v)
);

// File: tb/sim_shl_flag_unit.sv
module sim_shl_flag_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] operand;
  logic        byte_mode;
  logic        use_carry;
  logic        carry_in;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_c, flag_z, flag_n, flag_v;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shl_flag_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .byte_mode(byte_mode), .use_carry(use_carry), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_c(flag_c), .flag_z(flag_z),
    .flag_n(flag_n), .flag_v(flag_v)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input int op, input bit bm, input bit uc, input bit ci);
    int lo, fill, res, c, v, n, z;
    @(negedge clk);
    operand = op[15:0]; byte_mode = bm; use_carry = uc; carry_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    fill = (uc && ci) ? 1 : 0;
    if (bm) begin
      lo  = op % 256;
      res = (lo * 2 + fill) % 256;
      c   = (lo >= 128) ? 1 : 0;
      v   = (lo >= 'h40 && lo <= 'hBF) ? 1 : 0;
      n   = (res >= 128) ? 1 : 0;
    end else begin
      res = (op * 2 + fill) % 65536;
      c   = (op >= 32768) ? 1 : 0;
      v   = (op >= 'h4000 && op <= 'hBFFF) ? 1 : 0;
      n   = (res >= 32768) ? 1 : 0;
    end
    z = (res == 0) ? 1 : 0;
    chk("R2 out_valid", int'(out_valid), 1);
    chk(bm ? "R5 byte result" : (uc ? "R4 word rotate" : "R3 word shift"), int'(result), res);
    chk("R6 carry", int'(flag_c), c);
    chk("R7 zero", int'(flag_z), z);
    chk("R8 negative", int'(flag_n), n);
    chk("R9 overflow", int'(flag_v), v);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=195000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] held;
    rst = 1'b1; in_valid = 1'b0; operand = '0; byte_mode = 1'b0;
    use_carry = 1'b0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset flags", int'({flag_c, flag_z, flag_n, flag_v}), 0);
    rst = 1'b0;

    apply('h4000, 1'b0, 1'b0, 1'b0);
    chk("R9 0x4000 gives 0x8000", int'(result), 'h8000);

    for (int op = 0; op < 65536; op++)
      apply(op, 1'b0, op[0], op[1] ^ op[5]);

    for (int op = 0; op < 256; op++)
      for (int k = 0; k < 4; k++)
        apply(op + ((op * 37 + k * 91) % 256) * 256, 1'b1, k[0], k[1]);

    apply('h7FC0, 1'b1, 1'b1, 1'b1);
    held = result;
    @(negedge clk);
    chk("R2 idle out_valid", int'(out_valid), 0);
    chk("R2 idle hold", int'(result), int'(held));
    operand = 'hFFFF; byte_mode = 1'b0;
    @(negedge clk);
    chk("R2 idle ignores operand", int'(result), int'(held));

    begin
      int low_r, low_c;
      apply('hC001, 1'b0, 1'b0, 1'b0);
      low_r = int'(result);
      low_c = int'(flag_c);
      apply('h4000, 1'b0, 1'b1, low_c[0]);
      chk("R10 chain low", low_r, 'h8002);
      chk("R10 chain high", int'(result), 'h8001);
    end

    @(negedge clk);
    operand = 'h1234; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset result", int'(result), 0);
    chk("R1 mid reset valid", int'(out_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule